// File: doc/BRIEF.md
# Quadrant Coincidence Trigger Unit

The unit forms a level-0 single-track trigger for a two-plane hodoscope whose counters are summed into quadrants. It receives eight summed channels: lanes 0 to 3 carry the vertical-plane quadrants and lanes 4 to 7 carry the horizontal-plane quadrants. Each lane has a low-threshold hit strobe with a TDC timestamp. It also has a high-threshold strobe, which uses the same timestamp lane. A trigger is raised when a vertical quadrant and the horizontal quadrant it is paired with are hit at nearly the same time. A high-threshold hit on either member of that pair suppresses the trigger, because such a hit points to more than one track in the sum.

Every lane keeps its most recent low-threshold hit and its most recent high-threshold hit for a programmable number of clock cycles. A fresh hit is tested against the other fresh hit of its pair, or else against the stored hit of its partner. The coincidence window is a register counted in TDC units. Its reset value is 40 units, which is 10 ns at 250 ps per unit. After each trigger, a programmable dead time blocks further triggers. Alongside the trigger, the unit reports how many lanes of each plane were hit.

Top module: `quad_coinc_trig`

## Requirements
- R1: While reset is asserted and directly after it, `trig_o`, `trig_ts_o`, `trig_pair_o`, `cnt_v_o` and `cnt_h_o` are zero, no stored hit is valid, and the window register holds 40.
- R2: Pair p (0..3) joins lane p (vertical) with lane p+4 (horizontal). Hits on lanes that are not paired, for example lane 0 with lane 5, never produce a trigger.
- R3: Two hit times coincide only when their circular distance modulo 2^TS_W is strictly below the window register. A write with `cfg_win_we_i` takes effect from the next clock edge.
- R4: A hit captured at edge c can match a fresh partner hit evaluated at edge c+k for 1 <= k <= `cfg_hold_i`, and not later. A newer hit on the same lane replaces the stored one.
- R5: `trig_ts_o` is the later of the two matched times in circular order. Two fresh hits take precedence over a fresh vertical hit against a stored horizontal hit, and that takes precedence over a fresh horizontal hit against a stored vertical hit.
- R6: When several unvetoed pairs coincide in the same cycle, `trig_pair_o` reports the lowest pair index.
- R7: A pair is vetoed when any high-threshold hit on either of its lanes lies within the window of the trigger time. This covers a fresh high-threshold hit and a stored one inside the hold time. A vetoed pair does not block a higher pair.
- R8: After a trigger, the next `cfg_dead_i` evaluations produce no trigger. Coincidences that occur in that time are dropped, not queued.
- R9: `cnt_v_o` and `cnt_h_o` give the number of lanes 0..3 and lanes 4..7 that had a low-threshold strobe in the previous cycle.
- R10: A trigger appears one clock after the hits that cause it, as a single-cycle pulse. `trig_ts_o` and `trig_pair_o` are zero in cycles without a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_vld_i | input | 8 | Low-threshold hit strobe per lane |
| hi_vld_i | input | 8 | High-threshold hit strobe per lane |
| hit_ts_i | input | 8*TS_W | Timestamp per lane, lane n at bits n*TS_W upward |
| cfg_win_we_i | input | 1 | Load strobe for the window register |
| cfg_win_i | input | TS_W | New coincidence window in TDC units |
| cfg_hold_i | input | HOLD_W | Number of cycles a stored hit stays usable |
| cfg_dead_i | input | DEAD_W | Dead time in cycles after a trigger |
| trig_o | output | 1 | Trigger pulse |
| trig_ts_o | output | TS_W | Trigger time |
| trig_pair_o | output | 2 | Index of the firing pair |
| cnt_v_o | output | 3 | Vertical-plane lane hit count |
| cnt_h_o | output | 3 | Horizontal-plane lane hit count |

## Verification
The dead-time property assumes that `cfg_dead_i` does not change while a dead interval is running. The bench therefore sets the hold and dead values before reset is released and never changes them afterwards. The bench writes the window register only in cycles without hits. The properties place no limit on timestamps, so the random phase lets timestamps wrap around 2^16. It also mixes high-threshold strobes with low-threshold hits, so that the veto and precedence paths are exercised next to the wrap.

// File: rtl/qct_pkg.sv
package qct_pkg;
  localparam int unsigned N_PAIR = 4;
  localparam int unsigned N_CH   = 2 * N_PAIR;
  localparam int unsigned IDX_W  = $clog2(N_PAIR);
  localparam int unsigned CNT_W  = $clog2(N_PAIR + 1);

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_BOTH,
    SRC_V_NEW,
    SRC_H_NEW
  } coinc_src_e;
endpackage

// File: rtl/qct_chan_store.sv
module qct_chan_store #(
  parameter int unsigned TS_W   = 16,
  parameter int unsigned HOLD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              new_i,
  input  logic [TS_W-1:0]   ts_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              vld_o,
  output logic [TS_W-1:0]   ts_o
);
  logic [HOLD_W-1:0] age_q;
  logic [TS_W-1:0]   ts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= '0;
      ts_q  <= '0;
    end else if (new_i) begin
      age_q <= hold_i;
      ts_q  <= ts_i;
    end else if (age_q != '0) begin
      age_q <= age_q - 1'b1;
    end
  end

  assign vld_o = (age_q != '0);
  assign ts_o  = ts_q;

  AST_ENTRY_EXPIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(new_i) && ($past(age_q) == '0)) |-> !vld_o); // R4
endmodule

// File: rtl/qct_pair_eval.sv
module qct_pair_eval
  import qct_pkg::*;
#(
  parameter int unsigned TS_W = 16
) (
  input  logic [TS_W-1:0] win_i,
  input  logic            v_new_i,
  input  logic [TS_W-1:0] v_ts_i,
  input  logic            v_st_vld_i,
  input  logic [TS_W-1:0] v_st_ts_i,
  input  logic            h_new_i,
  input  logic [TS_W-1:0] h_ts_i,
  input  logic            h_st_vld_i,
  input  logic [TS_W-1:0] h_st_ts_i,
  input  logic            v_hi_new_i,
  input  logic            v_hi_vld_i,
  input  logic [TS_W-1:0] v_hi_ts_i,
  input  logic            h_hi_new_i,
  input  logic            h_hi_vld_i,
  input  logic [TS_W-1:0] h_hi_ts_i,
  output logic            ok_o,
  output logic [TS_W-1:0] ts_o
);
  function automatic logic [TS_W-1:0] cdist(input logic [TS_W-1:0] a, input logic [TS_W-1:0] b);
    logic [TS_W-1:0] d;
    d = a - b;
    return d[TS_W-1] ? (~d + 1'b1) : d;
  endfunction

  function automatic logic [TS_W-1:0] clater(input logic [TS_W-1:0] a, input logic [TS_W-1:0] b);
    logic [TS_W-1:0] d;
    d = a - b;
    return d[TS_W-1] ? b : a;
  endfunction

  logic       both_c, vs_c, hs_c, veto_c;
  coinc_src_e src;

  assign both_c = v_new_i && h_new_i    && (cdist(v_ts_i, h_ts_i)    < win_i);
  assign vs_c   = v_new_i && h_st_vld_i && (cdist(v_ts_i, h_st_ts_i) < win_i);
  assign hs_c   = h_new_i && v_st_vld_i && (cdist(h_ts_i, v_st_ts_i) < win_i);

  always_comb begin
    src  = SRC_NONE;
    ts_o = '0;
    if (both_c) begin
      src  = SRC_BOTH;
      ts_o = clater(v_ts_i, h_ts_i);
    end else if (vs_c) begin
      src  = SRC_V_NEW;
      ts_o = clater(v_ts_i, h_st_ts_i);
    end else if (hs_c) begin
      src  = SRC_H_NEW;
      ts_o = clater(h_ts_i, v_st_ts_i);
    end
  end

  // multi-track veto: any high-threshold hit of the pair near the trigger time
  always_comb begin
    veto_c = 1'b0;
    if (v_hi_new_i && (cdist(v_ts_i, ts_o)    < win_i)) veto_c = 1'b1;
    if (v_hi_vld_i && (cdist(v_hi_ts_i, ts_o) < win_i)) veto_c = 1'b1;
    if (h_hi_new_i && (cdist(h_ts_i, ts_o)    < win_i)) veto_c = 1'b1;
    if (h_hi_vld_i && (cdist(h_hi_ts_i, ts_o) < win_i)) veto_c = 1'b1;
  end

  assign ok_o = (src != SRC_NONE) && !veto_c;
endmodule

// File: rtl/qct_arbiter.sv
module qct_arbiter #(
  parameter int unsigned NP     = 4,
  parameter int unsigned TS_W   = 16,
  parameter int unsigned DEAD_W = 8,
  localparam int unsigned IW    = $clog2(NP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NP-1:0]    ok_i,
  input  logic [NP*TS_W-1:0] ts_i,
  input  logic [DEAD_W-1:0] dead_i,
  output logic             trig_o,
  output logic [TS_W-1:0]  trig_ts_o,
  output logic [IW-1:0]    trig_idx_o
);
  logic          sel_vld, fire;
  logic [IW-1:0] sel_idx;
  logic [TS_W-1:0] sel_ts;
  logic [DEAD_W-1:0] dead_q;
  logic          trig_q;
  logic [TS_W-1:0] ts_q;
  logic [IW-1:0] idx_q;

  always_comb begin
    sel_vld = 1'b0;
    sel_idx = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (ok_i[i]) begin
        sel_vld = 1'b1;
        sel_idx = IW'(i);
      end
    end
  end

  assign sel_ts = ts_i[sel_idx*TS_W +: TS_W];
  assign fire   = sel_vld && (dead_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      ts_q   <= '0;
      idx_q  <= '0;
      dead_q <= '0;
    end else begin
      trig_q <= fire;
      ts_q   <= fire ? sel_ts : '0;
      idx_q  <= fire ? sel_idx : '0;
      if (fire)                dead_q <= dead_i;
      else if (dead_q != '0)   dead_q <= dead_q - 1'b1;
    end
  end

  assign trig_o     = trig_q;
  assign trig_ts_o  = ts_q;
  assign trig_idx_o = idx_q;

  AST_DEAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o && (dead_i != '0)) |=> !trig_o); // R8

  AST_LOWEST_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> (($past(ok_i) & ~({NP{1'b1}} << trig_idx_o)) == '0)); // R6

  AST_TRIG_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> ($past(ok_i) != '0)); // R10
endmodule

// File: rtl/quad_coinc_trig.sv
module quad_coinc_trig
  import qct_pkg::*;
#(
  parameter int unsigned TS_W    = 16,
  parameter int unsigned HOLD_W  = 8,
  parameter int unsigned DEAD_W  = 8,
  parameter int unsigned WIN_RST = 40
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_CH-1:0]      hit_vld_i,
  input  logic [N_CH-1:0]      hi_vld_i,
  input  logic [N_CH*TS_W-1:0] hit_ts_i,
  input  logic                 cfg_win_we_i,
  input  logic [TS_W-1:0]      cfg_win_i,
  input  logic [HOLD_W-1:0]    cfg_hold_i,
  input  logic [DEAD_W-1:0]    cfg_dead_i,
  output logic                 trig_o,
  output logic [TS_W-1:0]      trig_ts_o,
  output logic [IDX_W-1:0]     trig_pair_o,
  output logic [CNT_W-1:0]     cnt_v_o,
  output logic [CNT_W-1:0]     cnt_h_o
);
  logic [TS_W-1:0]        win_q;
  logic [N_CH-1:0]        lo_vld, hi_vld;
  logic [N_CH*TS_W-1:0]   lo_ts, hi_ts;
  logic [N_PAIR-1:0]      pair_ok;
  logic [N_PAIR*TS_W-1:0] pair_ts;
  logic [CNT_W-1:0]       cnt_v_q, cnt_h_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           win_q <= TS_W'(WIN_RST);
    else if (cfg_win_we_i) win_q <= cfg_win_i;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_lane
    qct_chan_store #(.TS_W(TS_W), .HOLD_W(HOLD_W)) u_lo (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .new_i (hit_vld_i[c]),
      .ts_i  (hit_ts_i[c*TS_W +: TS_W]),
      .hold_i(cfg_hold_i),
      .vld_o (lo_vld[c]),
      .ts_o  (lo_ts[c*TS_W +: TS_W])
    );
    qct_chan_store #(.TS_W(TS_W), .HOLD_W(HOLD_W)) u_hi (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .new_i (hi_vld_i[c]),
      .ts_i  (hit_ts_i[c*TS_W +: TS_W]),
      .hold_i(cfg_hold_i),
      .vld_o (hi_vld[c]),
      .ts_o  (hi_ts[c*TS_W +: TS_W])
    );
  end

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    localparam int unsigned VC = p;
    localparam int unsigned HC = p + N_PAIR;
    qct_pair_eval #(.TS_W(TS_W)) u_eval (
      .win_i     (win_q),
      .v_new_i   (hit_vld_i[VC]),
      .v_ts_i    (hit_ts_i[VC*TS_W +: TS_W]),
      .v_st_vld_i(lo_vld[VC]),
      .v_st_ts_i (lo_ts[VC*TS_W +: TS_W]),
      .h_new_i   (hit_vld_i[HC]),
      .h_ts_i    (hit_ts_i[HC*TS_W +: TS_W]),
      .h_st_vld_i(lo_vld[HC]),
      .h_st_ts_i (lo_ts[HC*TS_W +: TS_W]),
      .v_hi_new_i(hi_vld_i[VC]),
      .v_hi_vld_i(hi_vld[VC]),
      .v_hi_ts_i (hi_ts[VC*TS_W +: TS_W]),
      .h_hi_new_i(hi_vld_i[HC]),
      .h_hi_vld_i(hi_vld[HC]),
      .h_hi_ts_i (hi_ts[HC*TS_W +: TS_W]),
      .ok_o      (pair_ok[p]),
      .ts_o      (pair_ts[p*TS_W +: TS_W])
    );

    AST_FRESH_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pair_ok[p] |-> (hit_vld_i[VC] || hit_vld_i[HC])); // R4
  end

  qct_arbiter #(.NP(N_PAIR), .TS_W(TS_W), .DEAD_W(DEAD_W)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ok_i      (pair_ok),
    .ts_i      (pair_ts),
    .dead_i    (cfg_dead_i),
    .trig_o    (trig_o),
    .trig_ts_o (trig_ts_o),
    .trig_idx_o(trig_pair_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_v_q <= '0;
      cnt_h_q <= '0;
    end else begin
      cnt_v_q <= CNT_W'($countones(hit_vld_i[N_PAIR-1:0]));
      cnt_h_q <= CNT_W'($countones(hit_vld_i[N_CH-1:N_PAIR]));
    end
  end

  assign cnt_v_o = cnt_v_q;
  assign cnt_h_o = cnt_h_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_v_o <= CNT_W'(N_PAIR)) && (cnt_h_o <= CNT_W'(N_PAIR))); // R9
endmodule

// File: tb/quad_coinc_trig_tb_top.sv
`timescale 1ns/1ps
module quad_coinc_trig_tb_top;
  localparam int TSW  = 16;
  localparam int MOD  = 1 << TSW;
  localparam int HOLD = 4;
  localparam int DEAD = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [7:0]        hit_vld_i = '0;
  logic [7:0]        hi_vld_i = '0;
  logic [8*TSW-1:0]  hit_ts_i = '0;
  logic              cfg_win_we_i = 1'b0;
  logic [TSW-1:0]    cfg_win_i = '0;
  logic [7:0]        cfg_hold_i = 8'(HOLD);
  logic [7:0]        cfg_dead_i = 8'(DEAD);
  logic              trig_o;
  logic [TSW-1:0]    trig_ts_o;
  logic [1:0]        trig_pair_o;
  logic [2:0]        cnt_v_o, cnt_h_o;

  quad_coinc_trig dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_vld_i(hit_vld_i), .hi_vld_i(hi_vld_i),
    .hit_ts_i(hit_ts_i), .cfg_win_we_i(cfg_win_we_i), .cfg_win_i(cfg_win_i),
    .cfg_hold_i(cfg_hold_i), .cfg_dead_i(cfg_dead_i), .trig_o(trig_o),
    .trig_ts_o(trig_ts_o), .trig_pair_o(trig_pair_o), .cnt_v_o(cnt_v_o), .cnt_h_o(cnt_h_o)
  );

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int  ts_arr[8];
  int  lo_ts[8], hi_ts[8], lo_cyc[8], hi_cyc[8];
  bit  lo_ok[8], hi_ok[8];
  int  win_m = 40;
  int  ev = 0;
  int  last_trig = -1000;
  int  exp_trig = 0, exp_ts = 0, exp_pair = 0, exp_cv = 0, exp_ch = 0;
  string exp_req = "R1";

  function automatic int cdist(int a, int b);
    int d;
    d = (a - b) & (MOD - 1);
    return (d >= MOD / 2) ? MOD - d : d;
  endfunction

  function automatic int clater(int a, int b);
    int d;
    d = (a - b) & (MOD - 1);
    return (d >= MOD / 2) ? b : a;
  endfunction

  function automatic bit usable_lo(int c);
    return lo_ok[c] && (ev - lo_cyc[c] <= HOLD);
  endfunction

  function automatic bit usable_hi(int c);
    return hi_ok[c] && (ev - hi_cyc[c] <= HOLD);
  endfunction

  task automatic model(input logic [7:0] lo, input logic [7:0] hi);
    int sel, sel_ts;
    sel = -1;
    sel_ts = 0;
    for (int p = 3; p >= 0; p--) begin
      int v, h, t;
      bit hit, veto;
      v = p; h = p + 4; hit = 0; t = 0; veto = 0;
      if (lo[v] && lo[h] && cdist(ts_arr[v], ts_arr[h]) < win_m) begin
        hit = 1; t = clater(ts_arr[v], ts_arr[h]);
      end else if (lo[v] && usable_lo(h) && cdist(ts_arr[v], lo_ts[h]) < win_m) begin
        hit = 1; t = clater(ts_arr[v], lo_ts[h]);
      end else if (lo[h] && usable_lo(v) && cdist(ts_arr[h], lo_ts[v]) < win_m) begin
        hit = 1; t = clater(ts_arr[h], lo_ts[v]);
      end
      if (hi[v] && cdist(ts_arr[v], t) < win_m) veto = 1;
      if (hi[h] && cdist(ts_arr[h], t) < win_m) veto = 1;
      if (usable_hi(v) && cdist(hi_ts[v], t) < win_m) veto = 1;
      if (usable_hi(h) && cdist(hi_ts[h], t) < win_m) veto = 1;
      if (hit && !veto) begin sel = p; sel_ts = t; end
    end
    exp_trig = 0; exp_ts = 0; exp_pair = 0;
    if (sel >= 0 && (ev - last_trig > DEAD)) begin
      exp_trig = 1; exp_ts = sel_ts; exp_pair = sel; last_trig = ev;
    end
    exp_cv = 0; exp_ch = 0;
    for (int c = 0; c < 8; c++) begin
      if (lo[c]) begin
        if (c < 4) exp_cv++; else exp_ch++;
        lo_ok[c] = 1; lo_cyc[c] = ev; lo_ts[c] = ts_arr[c];
      end
      if (hi[c]) begin
        hi_ok[c] = 1; hi_cyc[c] = ev; hi_ts[c] = ts_arr[c];
      end
    end
    ev++;
  endtask

  task automatic check_one(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", exp_req, what, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    check_one("trig", int'(trig_o), exp_trig);
    check_one("ts", int'(trig_ts_o), exp_ts);
    check_one("pair", int'(trig_pair_o), exp_pair);
    check_one("cnt_v", int'(cnt_v_o), exp_cv);
    check_one("cnt_h", int'(cnt_h_o), exp_ch);
  endtask

  task automatic step(input logic [7:0] lo, input logic [7:0] hi, input string req);
    @(negedge clk_i);
    check_outputs();
    cfg_win_we_i = 1'b0;
    hit_vld_i = lo;
    hi_vld_i = hi;
    for (int c = 0; c < 8; c++) hit_ts_i[c*TSW +: TSW] = TSW'(ts_arr[c]);
    model(lo, hi);
    exp_req = req;
  endtask

  task automatic set_win(input int w);
    @(negedge clk_i);
    check_outputs();
    hit_vld_i = '0;
    hi_vld_i = '0;
    cfg_win_we_i = 1'b1;
    cfg_win_i = TSW'(w);
    model(8'h00, 8'h00);
    win_m = w;
    exp_req = "R3";
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(8'h00, 8'h00, "R10");
  endtask

  task automatic set_ts(input int v, input int t);
    ts_arr[v] = t & (MOD - 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    for (int c = 0; c < 8; c++) begin
      ts_arr[c] = 0; lo_ok[c] = 0; hi_ok[c] = 0; lo_cyc[c] = 0; hi_cyc[c] = 0;
      lo_ts[c] = 0; hi_ts[c] = 0;
    end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset values observed at the first step
    idle(2);

    // R2: paired lanes fire, unpaired lanes do not
    set_ts(0, 100); set_ts(4, 105);
    step(8'h11, 8'h00, "R2");
    idle(8);
    set_ts(0, 300); set_ts(5, 302);
    step(8'h21, 8'h00, "R2");
    idle(8);

    // R3: window boundary with reset value 40, then reprogrammed to 10
    set_ts(1, 1000); set_ts(5, 1039);
    step(8'h22, 8'h00, "R3");
    idle(8);
    set_ts(1, 2000); set_ts(5, 2040);
    step(8'h22, 8'h00, "R3");
    idle(8);
    set_win(10);
    set_ts(1, 3000); set_ts(5, 3009);
    step(8'h22, 8'h00, "R3");
    idle(8);
    set_ts(1, 3100); set_ts(5, 3110);
    step(8'h22, 8'h00, "R3");
    idle(8);
    set_win(40);
    idle(1);

    // R4: stored partner within and beyond hold time
    set_ts(2, 4000);
    step(8'h04, 8'h00, "R4");
    idle(1);
    set_ts(6, 4010);
    step(8'h40, 8'h00, "R4");
    idle(8);
    set_ts(3, 5000);
    step(8'h08, 8'h00, "R4");
    idle(HOLD - 1);
    set_ts(7, 5005);
    step(8'h80, 8'h00, "R4");
    idle(8);
    set_ts(3, 6000);
    step(8'h08, 8'h00, "R4");
    idle(HOLD);
    set_ts(7, 6005);
    step(8'h80, 8'h00, "R4");
    idle(8);

    // R5: later time, including wrap
    set_ts(0, 7200); set_ts(4, 7190);
    step(8'h11, 8'h00, "R5");
    idle(8);
    set_ts(0, MOD - 6); set_ts(4, 5);
    step(8'h11, 8'h00, "R5");
    idle(8);

    // R6: two pairs at once
    set_ts(1, 8000); set_ts(5, 8001); set_ts(3, 8002); set_ts(7, 8003);
    step(8'hAA, 8'h00, "R6");
    idle(8);

    // R7: fresh veto, stored veto far and near, vetoed pair leaves higher pair
    set_ts(0, 9000); set_ts(4, 9003);
    step(8'h11, 8'h10, "R7");
    idle(8);
    set_ts(4, 9500);
    step(8'h10, 8'h10, "R7");
    idle(1);
    set_ts(0, 9600); set_ts(4, 9601);
    step(8'h11, 8'h00, "R7");
    idle(8);
    set_ts(0, 9800);
    step(8'h01, 8'h01, "R7");
    set_ts(4, 9810);
    step(8'h10, 8'h00, "R7");
    idle(8);
    set_ts(0, 10000); set_ts(4, 10001); set_ts(2, 10002); set_ts(6, 10003);
    step(8'h55, 8'h01, "R7");
    idle(8);

    // R8: dead time after a trigger
    for (int i = 0; i < 7; i++) begin
      set_ts(1, 11000 + 100 * i); set_ts(5, 11000 + 100 * i + 1);
      step(8'h22, 8'h00, "R8");
    end
    idle(8);

    // R9: plane counts
    step(8'h0F, 8'h00, "R9");
    step(8'hE0, 8'h00, "R9");
    step(8'h35, 8'h00, "R9");
    idle(8);

    // random phase with wrapping timestamps
    begin
      int base;
      base = MOD - 3000;
      for (int i = 0; i < 500; i++) begin
        logic [7:0] lo, hi;
        lo = 8'($urandom) & 8'($urandom);
        hi = lo & 8'($urandom) & 8'($urandom) & 8'($urandom);
        for (int c = 0; c < 8; c++) set_ts(c, base + int'($urandom_range(0, 70)));
        step(lo, hi, "R2");
        base = (base + 23) & (MOD - 1);
      end
    end
    idle(2);

    done = 1;
    finish_run();
  end
endmodule